// File: doc/BRIEF.md
# Flash Word Write Buffer with Forced Flush

This block gathers narrow bus writes into a single wide flash word before that word is programmed. Each accepted write carries a bus-word address, a data beat and a byte-enable strobe. The block merges the enabled bytes into one shared buffer and tracks which byte positions hold data. When every byte of the flash word is present, the block raises a program request on its own. It holds that request, with the word address, the target bank and the data, until the array side acknowledges it.

Software can also flush a partly filled word by setting a force flag. In that case every byte position that was never written goes out as 8'hFF. The flush happens only if the buffer holds data and all of that data arrived through secure writes. If the buffer is empty, the force flag drops again with no other effect. If any buffered byte came from a non-secure write, the force flag drops and the buffer contents stay as they are.

There are two misuse cases. Writing a byte position that is already filled is a strobe error. A write aimed at a different flash word or bank than the one being collected is an inconsistency error. Either error discards the offending write and empties the buffer. A strobe error can also raise an interrupt pulse when that interrupt is enabled.

Top module: `flash_wbuf`

## Requirements
- R1: After reset, pgm_req, fw_pending, strb_err, inc_err and strb_irq are all 0, and the buffer is empty.
- R2: While prog_en is 0, writes are ignored and do not change the buffer.
- R3: Address bits [SLOT_W-1:0] of wr_addr select the bus slot inside the word: slot s, strobe lane l maps to buffer byte s*BUS_BYTES+l, which is pgm_data bits [8*byte+7:8*byte]. The upper address bits are the flash word index. The write that completes the byte mask raises pgm_req on the following clock, with pgm_data equal to the merged bytes and pgm_word equal to that index.
- R4: pgm_req, together with pgm_data, pgm_word and pgm_bank, stays stable until a cycle with pgm_ack. After the acknowledging edge, pgm_req is 0 and the buffer is empty.
- R5: When fw_set is pulsed while the buffer holds only secure data, pgm_req rises two clocks after the fw_set edge. In pgm_data, every byte position that was never written is 8'hFF.
- R6: A force request finds the buffer empty, or finds that some buffered byte was written with wr_secure=0. In either case fw_pending is high for exactly one cycle and no program request follows.
- R7: A declined force on a buffer holding non-secure data leaves the buffer contents in place, so later writes can still complete that word.
- R8: fw_pending stays 1 through a forced program operation, clears on pgm_ack, and further fw_set pulses during that operation start no additional request.
- R9: A write that enables a byte position already valid in the buffer causes a one-cycle strb_err pulse, is discarded, and empties the buffer.
- R10: strb_irq pulses together with strb_err when strb_ie is 1, and stays 0 when strb_ie is 0.
- R11: A write to a non-empty buffer whose word index or wr_bank differs from the buffered word causes a one-cycle inc_err pulse, is discarded, and empties the buffer.
- R12: Writes arriving while a program request is outstanding, or while a force request is pending, are discarded without error.
- R13: pgm_bank equals the wr_bank value of the writes that filled the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_en | input | 1 | Program mode enable; writes are accepted only while 1 |
| wr_valid | input | 1 | Write beat present |
| wr_addr | input | ADDR_W | Bus-word address (slot in low bits, flash word above) |
| wr_data | input | 8*BUS_BYTES | Write data |
| wr_strb | input | BUS_BYTES | Byte enables of the beat |
| wr_bank | input | 1 | Target bank of the beat |
| wr_secure | input | 1 | Beat was issued by a secure master |
| fw_set | input | 1 | Pulse that requests a forced flush |
| strb_ie | input | 1 | Strobe error interrupt enable |
| pgm_ack | input | 1 | Array side accepts the outstanding program request |
| pgm_req | output | 1 | Program request |
| pgm_word | output | ADDR_W-SLOT_W | Flash word index of the request |
| pgm_bank | output | 1 | Bank of the request |
| pgm_data | output | 8*WORD_BYTES | Flash word, unwritten bytes as 8'hFF |
| fw_pending | output | 1 | Force flag state |
| strb_err | output | 1 | Strobe error pulse |
| inc_err | output | 1 | Inconsistency error pulse |
| strb_irq | output | 1 | Strobe error interrupt pulse |

## Verification
The merge path is tested with several fills. One is an in-order fill of all slots, which shows that a request appears only on the completing beat. Another is a partial-lane fill followed by a forced flush, which separates padded bytes from written ones. A third refills after a discarded beat and checks that later data lands in the right lanes. Writes made with program mode off, followed by overlapping writes with it on, show that nothing was latched in the first pass. The repeat-byte and wrong-word or wrong-bank patterns each show that only the offending beat is dropped and that the buffer restarts empty. A force request on an empty buffer and one on a non-secure buffer are told apart from a real flush by the absence of a request and, in the non-secure case, by the word still completing afterwards.

// File: rtl/flash_wbuf_pkg.sv
`timescale 1ns/1ps
package flash_wbuf_pkg;
   // collector phase: gathering bytes, or waiting on the array side
   typedef enum logic {
      WB_COLLECT = 1'b0,
      WB_PROGRAM = 1'b1
   } wb_state_e;

   localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/flash_wbuf_lanes.sv
`timescale 1ns/1ps
module flash_wbuf_lanes
   import flash_wbuf_pkg::*;
#(
   parameter int WORD_BYTES = 16,
   parameter int BUS_BYTES  = 4,
   localparam int SLOT_W    = $clog2(WORD_BYTES / BUS_BYTES),
   localparam int DATA_W    = WORD_BYTES * 8,
   localparam int BUS_W     = BUS_BYTES * 8
) (
   input  logic [SLOT_W-1:0]     slot,
   input  logic [BUS_BYTES-1:0]  strb,
   input  logic [BUS_W-1:0]      bus_data,
   input  logic [WORD_BYTES-1:0] mask_q,
   input  logic [DATA_W-1:0]     data_q,
   output logic [WORD_BYTES-1:0] hit,
   output logic [DATA_W-1:0]     merged,
   output logic [DATA_W-1:0]     padded,
   output logic                  overlap
);
   for (genvar i = 0; i < WORD_BYTES; i++) begin : g_byte
      localparam int SL = i / BUS_BYTES;
      localparam int LN = i % BUS_BYTES;
      assign hit[i]          = (slot == SLOT_W'(SL)) && strb[LN];
      assign merged[i*8 +: 8] = hit[i] ? bus_data[LN*8 +: 8] : data_q[i*8 +: 8];
      assign padded[i*8 +: 8] = mask_q[i] ? data_q[i*8 +: 8] : ERASED_BYTE;
   end

   assign overlap = |(hit & mask_q);
endmodule

// File: rtl/flash_wbuf_ctrl.sv
`timescale 1ns/1ps
module flash_wbuf_ctrl
   import flash_wbuf_pkg::*;
#(
   parameter int WORD_BYTES = 16,
   parameter int WORD_W     = 12,
   localparam int DATA_W    = WORD_BYTES * 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  prog_en,
   input  logic                  wr_valid,
   input  logic [WORD_W-1:0]     wr_word,
   input  logic                  wr_bank,
   input  logic                  wr_secure,
   input  logic                  fw_set,
   input  logic                  strb_ie,
   input  logic                  pgm_ack,
   input  logic [WORD_BYTES-1:0] hit,
   input  logic                  overlap,
   input  logic [DATA_W-1:0]     merged,
   output logic [WORD_BYTES-1:0] mask_q,
   output logic [DATA_W-1:0]     data_q,
   output logic [WORD_W-1:0]     word_q,
   output logic                  bank_q,
   output logic                  busy,
   output logic                  fw_q,
   output logic                  strb_err,
   output logic                  inc_err,
   output logic                  strb_irq
);
   wb_state_e st_q;
   logic      sec_q;
   logic      nonempty;
   logic      mismatch;
   logic      accept;
   logic [WORD_BYTES-1:0] new_mask;

   assign nonempty = |mask_q;
   assign mismatch = nonempty && ((wr_word != word_q) || (wr_bank != bank_q));
   assign accept   = wr_valid && prog_en;
   assign new_mask = mask_q | hit;
   assign busy     = (st_q == WB_PROGRAM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= WB_COLLECT;
         mask_q   <= '0;
         data_q   <= '0;
         word_q   <= '0;
         bank_q   <= 1'b0;
         sec_q    <= 1'b1;
         fw_q     <= 1'b0;
         strb_err <= 1'b0;
         inc_err  <= 1'b0;
         strb_irq <= 1'b0;
      end else begin
         strb_err <= 1'b0;
         inc_err  <= 1'b0;
         strb_irq <= 1'b0;
         if (st_q == WB_PROGRAM) begin
            // writes dropped here; a repeated force only keeps the flag up
            if (pgm_ack) begin
               st_q   <= WB_COLLECT;
               mask_q <= '0;
               fw_q   <= 1'b0;
            end else if (fw_set) begin
               fw_q <= 1'b1;
            end
         end else if (fw_q) begin
            // resolve the force request; beats in this cycle are dropped
            if (nonempty && sec_q) st_q <= WB_PROGRAM;
            else                   fw_q <= 1'b0;
         end else begin
            if (fw_set) fw_q <= 1'b1;
            if (accept) begin
               if (mismatch) begin
                  inc_err <= 1'b1;
                  mask_q  <= '0;
               end else if (overlap) begin
                  strb_err <= 1'b1;
                  strb_irq <= strb_ie;
                  mask_q   <= '0;
               end else begin
                  mask_q <= new_mask;
                  data_q <= merged;
                  word_q <= wr_word;
                  bank_q <= wr_bank;
                  sec_q  <= (nonempty ? sec_q : 1'b1) & wr_secure;
                  if (&new_mask) st_q <= WB_PROGRAM;
               end
            end
         end
      end
   end
endmodule

// File: rtl/flash_wbuf.sv
`timescale 1ns/1ps
module flash_wbuf #(
   parameter int WORD_BYTES = 16,
   parameter int BUS_BYTES  = 4,
   parameter int ADDR_W     = 14,
   localparam int SLOT_W    = $clog2(WORD_BYTES / BUS_BYTES),
   localparam int WORD_W    = ADDR_W - SLOT_W,
   localparam int DATA_W    = WORD_BYTES * 8,
   localparam int BUS_W     = BUS_BYTES * 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 prog_en,
   input  logic                 wr_valid,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [BUS_W-1:0]     wr_data,
   input  logic [BUS_BYTES-1:0] wr_strb,
   input  logic                 wr_bank,
   input  logic                 wr_secure,
   input  logic                 fw_set,
   input  logic                 strb_ie,
   input  logic                 pgm_ack,
   output logic                 pgm_req,
   output logic [WORD_W-1:0]    pgm_word,
   output logic                 pgm_bank,
   output logic [DATA_W-1:0]    pgm_data,
   output logic                 fw_pending,
   output logic                 strb_err,
   output logic                 inc_err,
   output logic                 strb_irq
);
   // elaboration-time parameter checks
   if (BUS_BYTES < 1 || (BUS_BYTES & (BUS_BYTES - 1)) != 0) begin : g_bad_bus
      $error("BUS_BYTES must be a power of two");
   end
   if (WORD_BYTES <= BUS_BYTES || (WORD_BYTES % BUS_BYTES) != 0
       || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
      $error("WORD_BYTES must be a power of two larger than BUS_BYTES");
   end
   if (ADDR_W <= SLOT_W) begin : g_bad_addr
      $error("ADDR_W too small for the slot field");
   end

   logic [SLOT_W-1:0]     slot;
   logic [WORD_W-1:0]     wr_word;
   logic [WORD_BYTES-1:0] hit;
   logic [WORD_BYTES-1:0] mask_q;
   logic [DATA_W-1:0]     data_q;
   logic [DATA_W-1:0]     merged;
   logic                  overlap;

   assign slot    = wr_addr[SLOT_W-1:0];
   assign wr_word = wr_addr[ADDR_W-1:SLOT_W];

   flash_wbuf_lanes #(
      .WORD_BYTES(WORD_BYTES),
      .BUS_BYTES (BUS_BYTES)
   ) u_lanes (
      .slot    (slot),
      .strb    (wr_strb),
      .bus_data(wr_data),
      .mask_q  (mask_q),
      .data_q  (data_q),
      .hit     (hit),
      .merged  (merged),
      .padded  (pgm_data),
      .overlap (overlap)
   );

   flash_wbuf_ctrl #(
      .WORD_BYTES(WORD_BYTES),
      .WORD_W    (WORD_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .prog_en  (prog_en),
      .wr_valid (wr_valid),
      .wr_word  (wr_word),
      .wr_bank  (wr_bank),
      .wr_secure(wr_secure),
      .fw_set   (fw_set),
      .strb_ie  (strb_ie),
      .pgm_ack  (pgm_ack),
      .hit      (hit),
      .overlap  (overlap),
      .merged   (merged),
      .mask_q   (mask_q),
      .data_q   (data_q),
      .word_q   (pgm_word),
      .bank_q   (pgm_bank),
      .busy     (pgm_req),
      .fw_q     (fw_pending),
      .strb_err (strb_err),
      .inc_err  (inc_err),
      .strb_irq (strb_irq)
   );
endmodule

// File: rtl/flash_wbuf_chk.sv
`timescale 1ns/1ps
module flash_wbuf_chk #(
   parameter int DATA_W = 128,
   parameter int WORD_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pgm_req,
   input logic              pgm_ack,
   input logic [DATA_W-1:0] pgm_data,
   input logic [WORD_W-1:0] pgm_word,
   input logic              pgm_bank,
   input logic              fw_pending,
   input logic              strb_err,
   input logic              inc_err,
   input logic              strb_irq
);
   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_req && !pgm_ack |=> pgm_req);
   // R4
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_req && pgm_ack |=> !pgm_req);
   // R4
   req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_req && !pgm_ack |=> $stable(pgm_data) && $stable(pgm_word) && $stable(pgm_bank));
   // R6
   fw_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fw_pending && !pgm_req |=> !fw_pending || pgm_req);
   // R8
   fw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fw_pending && pgm_req && !pgm_ack |=> fw_pending);
   // R10
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strb_irq |-> strb_err);
   // R9
   err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({strb_err, inc_err}));
   // R11
   err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strb_err || inc_err |-> !pgm_req);
endmodule

bind flash_wbuf flash_wbuf_chk #(
   .DATA_W(DATA_W),
   .WORD_W(WORD_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pgm_req   (pgm_req),
   .pgm_ack   (pgm_ack),
   .pgm_data  (pgm_data),
   .pgm_word  (pgm_word),
   .pgm_bank  (pgm_bank),
   .fw_pending(fw_pending),
   .strb_err  (strb_err),
   .inc_err   (inc_err),
   .strb_irq  (strb_irq)
);

// File: tb/sim_flash_wbuf.sv
`timescale 1ns/1ps
module sim_flash_wbuf;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         prog_en = 1'b0, wr_valid = 1'b0, wr_bank = 1'b0, wr_secure = 1'b1;
   logic [13:0]  wr_addr = '0;
   logic [31:0]  wr_data = '0;
   logic [3:0]   wr_strb = '0;
   logic         fw_set = 1'b0, strb_ie = 1'b0, pgm_ack = 1'b0;
   logic         pgm_req, pgm_bank, fw_pending, strb_err, inc_err, strb_irq;
   logic [11:0]  pgm_word;
   logic [127:0] pgm_data;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // bench model of the buffer
   logic [127:0] m_data;
   logic [15:0]  m_mask;

   always #4 clk = ~clk;

   flash_wbuf u0 (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
      chk(act === exp, req, what, act, exp);
   endtask

   function automatic logic [127:0] padded();
      logic [127:0] r;
      for (int i = 0; i < 16; i++) r[i*8 +: 8] = m_mask[i] ? m_data[i*8 +: 8] : 8'hFF;
      return r;
   endfunction

   task automatic m_clear();
      m_data = '0;
      m_mask = '0;
   endtask

   task automatic m_put(input int slot, input logic [31:0] d, input logic [3:0] s);
      for (int l = 0; l < 4; l++)
         if (s[l]) begin
            m_data[(slot*4 + l)*8 +: 8] = d[l*8 +: 8];
            m_mask[slot*4 + l] = 1'b1;
         end
   endtask

   // one write beat; returns at the falling edge after the capturing edge
   task automatic wr(input logic [11:0] word, input int slot, input logic [31:0] d,
                     input logic [3:0] s, input logic bank, input logic sec);
      @(negedge clk);
      wr_valid  = 1'b1;
      wr_addr   = {word, 2'(slot)};
      wr_data   = d;
      wr_strb   = s;
      wr_bank   = bank;
      wr_secure = sec;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic do_ack();
      @(negedge clk);
      pgm_ack = 1'b1;
      @(negedge clk);
      pgm_ack = 1'b0;
   endtask

   task automatic do_force();
      @(negedge clk);
      fw_set = 1'b1;
      @(negedge clk);
      fw_set = 1'b0;
   endtask

   task automatic t_reset();
      chk_eq("R1", "pgm_req", pgm_req, 0);
      chk_eq("R1", "fw_pending", fw_pending, 0);
      chk_eq("R1", "errors", {strb_err, inc_err, strb_irq}, 0);
   endtask

   // R2 writes off, then R3 full fill, R12 write during programming, R6 empty force
   task automatic t_prog_off_and_full();
      prog_en = 1'b0;
      for (int s = 0; s < 4; s++) wr(12'h034, s, 32'hDEAD0000 + s, 4'hF, 1'b1, 1'b1);
      chk_eq("R2", "pgm_req with prog_en low", pgm_req, 0);
      prog_en = 1'b1;
      m_clear();
      for (int s = 1; s < 4; s++) begin
         wr(12'h034, s, 32'h10203040 * (s + 1), 4'hF, 1'b1, 1'b1);
         m_put(s, 32'h10203040 * (s + 1), 4'hF);
         chk_eq("R2", "no strobe error on refill", strb_err, 0);
      end
      chk_eq("R3", "no request before last slot", pgm_req, 0);
      wr(12'h034, 0, 32'hA5B6C7D8, 4'hF, 1'b1, 1'b1);
      m_put(0, 32'hA5B6C7D8, 4'hF);
      chk_eq("R3", "request on full word", pgm_req, 1);
      chk_eq("R3", "pgm_data", pgm_data, m_data);
      chk_eq("R3", "pgm_word", pgm_word, 12'h034);
      chk_eq("R13", "pgm_bank", pgm_bank, 1);
      wr(12'h034, 0, 32'h0, 4'hF, 1'b1, 1'b1);
      chk_eq("R12", "write while busy: no strobe error", strb_err, 0);
      chk_eq("R12", "write while busy: data unchanged", pgm_data, m_data);
      repeat (3) @(negedge clk);
      chk_eq("R4", "request held", pgm_req, 1);
      do_ack();
      chk_eq("R4", "request dropped after ack", pgm_req, 0);
      do_force();
      chk_eq("R6", "fw_pending set on empty buffer", fw_pending, 1);
      @(negedge clk);
      chk_eq("R6", "fw_pending cleared", fw_pending, 0);
      chk_eq("R4", "buffer empty after ack: no force request", pgm_req, 0);
   endtask

   // R5 partial forced flush, R8 repeat force during operation
   task automatic t_force_partial();
      m_clear();
      wr(12'h050, 1, 32'h11223344, 4'b0110, 1'b0, 1'b1);
      m_put(1, 32'h11223344, 4'b0110);
      do_force();
      chk_eq("R5", "no request at flag edge", pgm_req, 0);
      @(negedge clk);
      chk_eq("R5", "forced request", pgm_req, 1);
      chk_eq("R5", "padded data", pgm_data, padded());
      chk_eq("R5", "pgm_word", pgm_word, 12'h050);
      do_force();
      chk_eq("R8", "fw_pending during operation", fw_pending, 1);
      do_ack();
      chk_eq("R8", "fw_pending cleared on ack", fw_pending, 0);
      repeat (2) @(negedge clk);
      chk_eq("R8", "no extra request", pgm_req, 0);
   endtask

   // R7 non-secure buffer keeps data after declined force
   task automatic t_force_nonsecure();
      m_clear();
      wr(12'h061, 0, 32'hCAFEF00D, 4'hF, 1'b0, 1'b0);
      m_put(0, 32'hCAFEF00D, 4'hF);
      do_force();
      @(negedge clk);
      chk_eq("R6", "declined force: no request", pgm_req, 0);
      chk_eq("R6", "declined force: flag cleared", fw_pending, 0);
      for (int s = 1; s < 4; s++) begin
         wr(12'h061, s, 32'h01010101 * s, 4'hF, 1'b0, 1'b1);
         m_put(s, 32'h01010101 * s, 4'hF);
      end
      chk_eq("R7", "word completes after declined force", pgm_req, 1);
      chk_eq("R7", "kept data", pgm_data, m_data);
      do_ack();
   endtask

   // R9 strobe error, R10 interrupt
   task automatic t_strobe();
      strb_ie = 1'b1;
      wr(12'h070, 2, 32'h99887766, 4'b0011, 1'b0, 1'b1);
      wr(12'h070, 2, 32'h55555555, 4'b0010, 1'b0, 1'b1);
      chk_eq("R9", "strb_err pulse", strb_err, 1);
      chk_eq("R10", "strb_irq with enable", strb_irq, 1);
      @(negedge clk);
      chk_eq("R9", "strb_err one cycle", strb_err, 0);
      m_clear();
      wr(12'h070, 0, 32'h0A0B0C0D, 4'hF, 1'b0, 1'b1); m_put(0, 32'h0A0B0C0D, 4'hF);
      wr(12'h070, 1, 32'h1A1B1C1D, 4'hF, 1'b0, 1'b1); m_put(1, 32'h1A1B1C1D, 4'hF);
      wr(12'h070, 3, 32'h3A3B3C3D, 4'hF, 1'b0, 1'b1); m_put(3, 32'h3A3B3C3D, 4'hF);
      chk_eq("R9", "buffer emptied: no request", pgm_req, 0);
      wr(12'h070, 2, 32'h2A2B2C2D, 4'hF, 1'b0, 1'b1); m_put(2, 32'h2A2B2C2D, 4'hF);
      chk_eq("R9", "request after refill", pgm_req, 1);
      chk_eq("R9", "refill data", pgm_data, m_data);
      do_ack();
      strb_ie = 1'b0;
      wr(12'h071, 0, 32'h1, 4'b0001, 1'b0, 1'b1);
      wr(12'h071, 0, 32'h2, 4'b0001, 1'b0, 1'b1);
      chk_eq("R9", "strb_err second", strb_err, 1);
      chk_eq("R10", "strb_irq masked", strb_irq, 0);
   endtask

   // R11 inconsistency on word and bank, R13 bank
   task automatic t_incons();
      wr(12'h080, 0, 32'hFEEDBEEF, 4'hF, 1'b0, 1'b1);
      wr(12'h081, 1, 32'h12345678, 4'hF, 1'b0, 1'b1);
      chk_eq("R11", "inc_err on word change", inc_err, 1);
      chk_eq("R11", "no strobe error", strb_err, 0);
      @(negedge clk);
      chk_eq("R11", "inc_err one cycle", inc_err, 0);
      m_clear();
      for (int s = 1; s < 4; s++) begin
         wr(12'h080, s, 32'h77000000 + s, 4'hF, 1'b0, 1'b1);
         chk_eq("R11", "no error after restart", inc_err, 0);
         m_put(s, 32'h77000000 + s, 4'hF);
      end
      chk_eq("R11", "slot 0 was discarded", pgm_req, 0);
      wr(12'h080, 0, 32'h66666666, 4'hF, 1'b1, 1'b1);
      chk_eq("R11", "inc_err on bank change", inc_err, 1);
      m_clear();
      for (int s = 0; s < 4; s++) begin
         wr(12'h080, s, 32'h44440000 + s, 4'hF, 1'b0, 1'b1);
         m_put(s, 32'h44440000 + s, 4'hF);
      end
      chk_eq("R11", "request after bank refill", pgm_req, 1);
      chk_eq("R11", "data after bank refill", pgm_data, m_data);
      chk_eq("R13", "bank 0 request", pgm_bank, 0);
      do_ack();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_prog_off_and_full();
      t_force_partial();
      t_force_nonsecure();
      t_strobe();
      t_incons();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule